// File: doc/BRIEF.md
# Posted Host Write Arbiter

This block lets an external host post a write into a local processor's memory space without being held off. The host's address and data are taken on the trailing edge of its write strobe. A pending flag is then raised, and the host is released at once. After that, the block takes the memory bus from the local CPU, runs one write cycle and gives the bus back. There are four targets: data memory, instruction memory (written as two bytes, low byte first), and the low and high bytes of the program counter.

The host is stalled only when it starts a second read or write while a posted write is still pending. The host strobes are plain level signals. They have no valid/ready handshake. Back-pressure to the host is given only through the active-low acknowledge, which is pulled low for as long as a new access overlaps a pending write. Local bus requests are granted while the machine is idle and in its one-cycle termination state. They are refused from the start of the access phase until termination. The target select and the wait-state settings are configuration levels, and they are sampled only between writes.

Top module: `latched_wr_arb`

## Requirements
- R1: After a synchronous active-high reset, the following hold: `bus_local`=1, `wr_pend_n`=1, `host_ack_n`=1, `dmem_we_n`=1, `imem_we_n`=1, `pclo_ld`=0 and `pchi_ld`=0. The instruction byte flag is cleared, so the next instruction-memory write is taken as a low byte.
- R2: In the idle and termination states, `lcl_gnt` follows `lcl_req` in the same cycle.
- R3: A first host write, with `host_en`=1, is never stalled: `host_ack_n` stays 1. Address and data are taken from the cycle in which `host_wr_n` rises. `wr_pend_n` goes low one cycle after that rise and keeps the captured values frozen.
- R4: While `wr_pend_n`=0, `host_ack_n` is 0 in any cycle where `host_en`=1 and either `host_wr_n` or `host_rd_n` is low.
- R5: `lcl_gnt` is 0 in every cycle in which `bus_local`=0.
- R6: `cfg_sel` encodes the target as follows: 00 data memory (`dmem_we_n`), 01 instruction memory (`imem_we_n`), 10 program counter low byte (`pclo_ld`), 11 program counter high byte (`pchi_ld`). Only one strobe is active at a time. `mem_addr` and `mem_wdata` carry the captured address and data.
- R7: `bus_local` falls one cycle after `cpu_wr_n` is seen high in the take-over state. While `cpu_wr_n` is low, the bus is held by the local side. Exactly one settle cycle with `bus_local`=0 comes before the strobe.
- R8: The strobe lasts 1+`cfg_dwait` cycles for data memory, 1+`cfg_iwait` cycles for an instruction high byte, and 1 cycle for a program counter byte. When the programmed count has run out, each cycle with `ext_wait_n`=0 adds one more cycle.
- R9: `bus_local` returns to 1 one cycle after the strobe ends. `wr_pend_n` and `host_ack_n` are released in that same cycle.
- R10: An instruction-memory low byte raises no strobe and is kept in a holding register. The following high byte strobes `imem_we_n` with `imem_wdata` = {high, low}. Each instruction-memory write toggles the byte flag.
- R11: A change to `cfg_sel`, `cfg_dwait` or `cfg_iwait` made during an access does not affect that access. It applies from the next write.
- R12: A host write whose strobe rises in the termination cycle sends the machine directly back to take-over. `bus_local` falls two cycles after termination, not three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-state clock |
| rst | input | 1 | Synchronous reset, active high |
| host_en | input | 1 | Host access enable |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_addr | input | AW | Host address |
| host_data | input | DW | Host write data |
| host_ack_n | output | 1 | Host acknowledge, low stalls the host |
| wr_pend_n | output | 1 | Posted write pending, active low |
| cfg_sel | input | 2 | Target select |
| cfg_dwait | input | DWAIT_W | Data memory wait states |
| cfg_iwait | input | IWAIT_W | Instruction memory wait states |
| lcl_req | input | 1 | Local CPU bus request |
| lcl_gnt | output | 1 | Local CPU bus grant |
| cpu_wr_n | input | 1 | Local CPU write strobe, active low |
| bus_local | output | 1 | 1 when the local CPU owns the bus |
| ext_wait_n | input | 1 | External wait, low extends the strobe |
| dmem_we_n | output | 1 | Data memory write strobe, active low |
| imem_we_n | output | 1 | Instruction memory write strobe, active low |
| pclo_ld | output | 1 | Program counter low byte load |
| pchi_ld | output | 1 | Program counter high byte load |
| mem_addr | output | AW | Captured write address |
| mem_wdata | output | DW | Captured write data |
| imem_wdata | output | 2*DW | Instruction word {high, low} |

## Verification
In the termination cycle, three things can happen at once: the pending flag and the host acknowledge are released, a stalled host raises its second write strobe, and a local bus request is granted. The bench makes this happen by issuing a second write while the first is still pending, holding the strobe low until the acknowledge goes high, and raising the strobe at that very sample. It then checks that the release and the grant fall in the same cycle, and that `bus_local` falls two cycles later instead of three. The scoreboard also checks the captured data of the second write against what was driven.

// File: rtl/arw_pkg.sv
package arw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_TAKE    = 3'd1,
    ST_SETTLE  = 3'd2,
    ST_STROBE  = 3'd3,
    ST_RELEASE = 3'd4,
    ST_TERM    = 3'd5
  } arw_state_e;

  localparam logic [1:0] SEL_DMEM = 2'b00;
  localparam logic [1:0] SEL_IMEM = 2'b01;
  localparam logic [1:0] SEL_PCLO = 2'b10;
  localparam logic [1:0] SEL_PCHI = 2'b11;
endpackage

// File: rtl/arw_host_capture.sv
module arw_host_capture #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_en,
  input  logic          host_wr_n,
  input  logic          host_rd_n,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_data,
  input  logic          clr_pend,
  output logic          pend,
  output logic          rise_evt,
  output logic          ack_n,
  output logic [AW-1:0] cap_addr,
  output logic [DW-1:0] cap_data
);
  logic          wr_q;
  logic          pend_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          take_data;

  // latch follows the host while its strobe was low, freezes once posted
  assign take_data = host_en && !pend_q && !wr_q;
  assign rise_evt  = take_data && host_wr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= 1'b1;
      pend_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      wr_q <= host_wr_n;
      if (take_data) begin
        addr_q <= host_addr;
        data_q <= host_data;
      end
      if (clr_pend)      pend_q <= 1'b0;
      else if (rise_evt) pend_q <= 1'b1;
    end
  end

  assign pend     = pend_q;
  assign ack_n    = !(pend_q && host_en && (!host_wr_n || !host_rd_n));
  assign cap_addr = addr_q;
  assign cap_data = data_q;

  AST_CAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (pend_q && $past(pend_q)) |-> ($stable(addr_q) && $stable(data_q))); // R3
endmodule

// File: rtl/arw_wait_ctr.sv
module arw_wait_ctr #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |-> (cnt_q != '0)); // R8
endmodule

// File: rtl/arw_sequencer.sv
module arw_sequencer
  import arw_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pend,
  input  logic          rise_evt,
  input  logic          cpu_wr_n,
  input  logic          ext_wait_n,
  input  logic          lcl_req,
  input  logic [1:0]    sel,
  input  logic [CW-1:0] dwait,
  input  logic [CW-1:0] iwait,
  input  logic [DW-1:0] cap_data,
  input  logic          cnt_zero,
  output logic          cnt_load,
  output logic [CW-1:0] cnt_val,
  output logic          cnt_dec,
  output logic          clr_pend,
  output logic          cfg_upd,
  output logic          bus_local,
  output logic          lcl_gnt,
  output logic          dmem_we_n,
  output logic          imem_we_n,
  output logic          pclo_ld,
  output logic          pchi_ld,
  output logic [DW-1:0] ilat
);
  arw_state_e    st_q, st_d;
  logic          hib_q;
  logic [DW-1:0] ilat_q;
  logic          in_strobe;
  logic          strb_any;

  always_comb begin
    st_d     = st_q;
    cnt_load = 1'b0;
    case (st_q)
      ST_IDLE:    if (pend) begin st_d = ST_TAKE; cnt_load = 1'b1; end
      ST_TAKE:    if (cpu_wr_n) st_d = ST_SETTLE;
      ST_SETTLE:  st_d = ST_STROBE;
      ST_STROBE:  if (cnt_zero && ext_wait_n) st_d = ST_RELEASE;
      ST_RELEASE: st_d = ST_TERM;
      ST_TERM: begin
        if (rise_evt) begin st_d = ST_TAKE; cnt_load = 1'b1; end
        else st_d = ST_IDLE;
      end
      default:    st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (sel == SEL_DMEM)                cnt_val = dwait;
    else if (sel == SEL_IMEM && hib_q)  cnt_val = iwait;
    else                                cnt_val = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      hib_q  <= 1'b0;
      ilat_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_RELEASE && sel == SEL_IMEM) begin
        if (!hib_q) ilat_q <= cap_data;
        hib_q <= !hib_q;
      end
    end
  end

  assign in_strobe = (st_q == ST_STROBE);
  assign cnt_dec   = in_strobe && !cnt_zero;
  assign clr_pend  = (st_q == ST_RELEASE);
  assign cfg_upd   = (st_q == ST_IDLE && !pend) || (st_q == ST_RELEASE);
  assign bus_local = !(st_q == ST_SETTLE || in_strobe || st_q == ST_RELEASE);
  assign lcl_gnt   = lcl_req && (st_q == ST_IDLE || st_q == ST_TERM);
  assign dmem_we_n = !(in_strobe && sel == SEL_DMEM);
  assign imem_we_n = !(in_strobe && sel == SEL_IMEM && hib_q);
  assign pclo_ld   = in_strobe && sel == SEL_PCLO;
  assign pchi_ld   = in_strobe && sel == SEL_PCHI;
  assign ilat      = ilat_q;
  assign strb_any  = !dmem_we_n || !imem_we_n || pclo_ld || pchi_ld;

  AST_NO_GNT_REMOTE: assert property (@(posedge clk) disable iff (rst)
    !bus_local |-> !lcl_gnt); // R5
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({!dmem_we_n, !imem_we_n, pclo_ld, pchi_ld})); // R6
  AST_STROBE_REMOTE: assert property (@(posedge clk) disable iff (rst)
    strb_any |-> !bus_local); // R7
  AST_SETTLE_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(strb_any) |-> $past(!bus_local)); // R7
  AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(strb_any) |-> !bus_local); // R9
endmodule

// File: rtl/latched_wr_arb.sv
module latched_wr_arb
  import arw_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int DWAIT_W = 3,
  parameter int IWAIT_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_en,
  input  logic               host_wr_n,
  input  logic               host_rd_n,
  input  logic [AW-1:0]      host_addr,
  input  logic [DW-1:0]      host_data,
  output logic               host_ack_n,
  output logic               wr_pend_n,
  input  logic [1:0]         cfg_sel,
  input  logic [DWAIT_W-1:0] cfg_dwait,
  input  logic [IWAIT_W-1:0] cfg_iwait,
  input  logic               lcl_req,
  output logic               lcl_gnt,
  input  logic               cpu_wr_n,
  output logic               bus_local,
  input  logic               ext_wait_n,
  output logic               dmem_we_n,
  output logic               imem_we_n,
  output logic               pclo_ld,
  output logic               pchi_ld,
  output logic [AW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  output logic [2*DW-1:0]    imem_wdata
);
  localparam int CW = (DWAIT_W > IWAIT_W) ? DWAIT_W : IWAIT_W;

  logic               pend, rise_evt, clr_pend, cfg_upd;
  logic               cnt_load, cnt_dec, cnt_zero;
  logic [CW-1:0]      cnt_val;
  logic [AW-1:0]      cap_addr;
  logic [DW-1:0]      cap_data, ilat;
  logic [1:0]         act_sel;
  logic [DWAIT_W-1:0] act_dwait;
  logic [IWAIT_W-1:0] act_iwait;

  // configuration is only sampled between writes
  always_ff @(posedge clk) begin
    if (rst) begin
      act_sel   <= SEL_DMEM;
      act_dwait <= '0;
      act_iwait <= '0;
    end else if (cfg_upd) begin
      act_sel   <= cfg_sel;
      act_dwait <= cfg_dwait;
      act_iwait <= cfg_iwait;
    end
  end

  arw_host_capture #(.AW(AW), .DW(DW)) cap_i (
    .clk(clk), .rst(rst), .host_en(host_en), .host_wr_n(host_wr_n),
    .host_rd_n(host_rd_n), .host_addr(host_addr), .host_data(host_data),
    .clr_pend(clr_pend), .pend(pend), .rise_evt(rise_evt), .ack_n(host_ack_n),
    .cap_addr(cap_addr), .cap_data(cap_data)
  );

  arw_wait_ctr #(.CW(CW)) ctr_i (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val),
    .dec(cnt_dec), .zero(cnt_zero)
  );

  arw_sequencer #(.DW(DW), .CW(CW)) seq_i (
    .clk(clk), .rst(rst), .pend(pend), .rise_evt(rise_evt),
    .cpu_wr_n(cpu_wr_n), .ext_wait_n(ext_wait_n), .lcl_req(lcl_req),
    .sel(act_sel), .dwait(CW'(act_dwait)), .iwait(CW'(act_iwait)),
    .cap_data(cap_data), .cnt_zero(cnt_zero), .cnt_load(cnt_load),
    .cnt_val(cnt_val), .cnt_dec(cnt_dec), .clr_pend(clr_pend),
    .cfg_upd(cfg_upd), .bus_local(bus_local), .lcl_gnt(lcl_gnt),
    .dmem_we_n(dmem_we_n), .imem_we_n(imem_we_n), .pclo_ld(pclo_ld),
    .pchi_ld(pchi_ld), .ilat(ilat)
  );

  assign wr_pend_n  = !pend;
  assign mem_addr   = cap_addr;
  assign mem_wdata  = cap_data;
  assign imem_wdata = {cap_data, ilat};

  AST_PEND_BUS_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_pend_n) |-> $rose(bus_local)); // R9
  AST_ACK_QUIET: assert property (@(posedge clk) disable iff (rst)
    wr_pend_n |-> host_ack_n); // R3
endmodule

// File: tb/latched_wr_arb_tb_top.sv
module latched_wr_arb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 8;

  logic clk, rst, host_en, host_wr_n, host_rd_n;
  logic [AW-1:0] host_addr;
  logic [DW-1:0] host_data;
  logic host_ack_n, wr_pend_n;
  logic [1:0] cfg_sel;
  logic [2:0] cfg_dwait;
  logic [1:0] cfg_iwait;
  logic lcl_req, lcl_gnt, cpu_wr_n, bus_local, ext_wait_n;
  logic dmem_we_n, imem_we_n, pclo_ld, pchi_ld;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [2*DW-1:0] imem_wdata;

  latched_wr_arb dut_i (
    .clk(clk), .rst(rst), .host_en(host_en), .host_wr_n(host_wr_n),
    .host_rd_n(host_rd_n), .host_addr(host_addr), .host_data(host_data),
    .host_ack_n(host_ack_n), .wr_pend_n(wr_pend_n), .cfg_sel(cfg_sel),
    .cfg_dwait(cfg_dwait), .cfg_iwait(cfg_iwait), .lcl_req(lcl_req),
    .lcl_gnt(lcl_gnt), .cpu_wr_n(cpu_wr_n), .bus_local(bus_local),
    .ext_wait_n(ext_wait_n), .dmem_we_n(dmem_we_n), .imem_we_n(imem_we_n),
    .pclo_ld(pclo_ld), .pchi_ld(pchi_ld), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .imem_wdata(imem_wdata)
  );

  // kind: 0 none, 1 data memory, 2 instruction memory, 3 pc low, 4 pc high
  typedef struct packed {
    logic [2:0]  kind;
    logic [15:0] addr;
    logic [15:0] data;
    logic [7:0]  slen;
  } exp_t;

  exp_t exp_q[$];
  int n_vec = 0;
  int n_bad = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push(input int kind, input logic [15:0] a, input logic [15:0] d, input int slen);
    exp_t e;
    e.kind = 3'(kind);
    e.addr = a;
    e.data = d;
    e.slen = 8'(slen);
    exp_q.push_back(e);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // monitor: measures each remote bus tenure and compares it with the scoreboard
  int m_off = 0, m_slen = 0, m_pre = 0;
  bit m_seen = 0, m_gnt_bad = 0;
  logic [2:0] m_kind;
  logic [15:0] m_addr, m_data;

  function automatic logic [2:0] strobe_kind();
    if (!dmem_we_n) return 3'd1;
    if (!imem_we_n) return 3'd2;
    if (pclo_ld)    return 3'd3;
    if (pchi_ld)    return 3'd4;
    return 3'd0;
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      m_off = 0; m_slen = 0; m_pre = 0; m_seen = 0; m_gnt_bad = 0; m_kind = 3'd0;
    end else if (!bus_local) begin
      if (lcl_gnt) m_gnt_bad = 1;
      if (strobe_kind() != 3'd0) begin
        if (!m_seen) begin
          m_seen = 1;
          m_pre  = m_off;
          m_kind = strobe_kind();
          m_addr = mem_addr;
          m_data = (m_kind == 3'd2) ? imem_wdata : {8'h00, mem_wdata};
        end
        m_slen++;
      end
      m_off++;
    end else if (m_off != 0) begin
      exp_t e;
      if (exp_q.size() == 0) begin
        chk("R6 unexpected access", 32'd1, 32'd0);
      end else begin
        e = exp_q.pop_front();
        chk("R6 target strobe", 32'(m_seen ? m_kind : 3'd0), 32'(e.kind));
        if (e.kind != 3'd0) begin
          chk("R6 address", 32'(m_addr), 32'(e.addr));
          chk("R10 data word", 32'(m_data), 32'(e.data));
          chk("R7 settle cycle", 32'(m_pre), 32'd1);
        end
        chk("R8 strobe length", 32'(m_slen), 32'(e.slen));
        chk("R9 bus return", 32'(m_off), (e.kind == 3'd0) ? 32'd3 : 32'(e.slen) + 32'd2);
      end
      chk("R9 pend released", 32'(wr_pend_n), 32'd1);
      chk("R2 grant in termination", 32'(lcl_gnt), 32'(lcl_req));
      chk("R5 no grant while remote", 32'(m_gnt_bad), 32'd0);
      m_off = 0; m_slen = 0; m_pre = 0; m_seen = 0; m_gnt_bad = 0;
    end
  end

  task automatic host_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_data = d; host_en = 1'b1; host_wr_n = 1'b0;
    @(negedge clk);
    chk("R3 first write not stalled", 32'(host_ack_n), 32'd1);
    @(negedge clk);
    host_wr_n = 1'b1;
    @(negedge clk);
    chk("R3 pend raised", 32'(wr_pend_n), 32'd0);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(bus_local && wr_pend_n));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; host_en = 1'b0; host_wr_n = 1'b1; host_rd_n = 1'b1;
    host_addr = '0; host_data = '0; cfg_sel = 2'b00; cfg_dwait = 3'd0;
    cfg_iwait = 2'd0; lcl_req = 1'b0; cpu_wr_n = 1'b1; ext_wait_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 bus_local", 32'(bus_local), 32'd1);
    chk("R1 pend", 32'(wr_pend_n), 32'd1);
    chk("R1 ack", 32'(host_ack_n), 32'd1);
    chk("R1 strobes", 32'({dmem_we_n, imem_we_n, pclo_ld, pchi_ld}), 32'b1100);
    // R2 idle grant
    lcl_req = 1'b1;
    @(negedge clk);
    chk("R2 idle grant", 32'(lcl_gnt), 32'd1);

    // R6 R8 data memory, no wait and maximum wait
    cfg_sel = 2'b00; cfg_dwait = 3'd0;
    push(1, 16'h1234, 16'h00a5, 1); host_write(16'h1234, 8'ha5); wait_idle();
    cfg_dwait = 3'd7;
    push(1, 16'h2345, 16'h005a, 8); host_write(16'h2345, 8'h5a); wait_idle();

    // R10 instruction memory byte pairs, iw 0 then max
    cfg_sel = 2'b01; cfg_iwait = 2'd0;
    push(0, 16'h0010, 16'h0000, 0); host_write(16'h0010, 8'h11); wait_idle();
    push(2, 16'h0011, 16'h2211, 1); host_write(16'h0011, 8'h22); wait_idle();
    cfg_iwait = 2'd3;
    push(0, 16'h0020, 16'h0000, 0); host_write(16'h0020, 8'h33); wait_idle();
    push(2, 16'h0021, 16'h4433, 4); host_write(16'h0021, 8'h44); wait_idle();

    // R6 R8 program counter bytes ignore the wait fields
    cfg_sel = 2'b10;
    push(3, 16'h0000, 16'h0077, 1); host_write(16'h0000, 8'h77); wait_idle();
    cfg_sel = 2'b11;
    push(4, 16'h0001, 16'h0088, 1); host_write(16'h0001, 8'h88); wait_idle();

    // R8 external wait extends the strobe; R4 read during pending stalls host
    cfg_sel = 2'b00; cfg_dwait = 3'd0; ext_wait_n = 1'b0;
    push(1, 16'h3000, 16'h0099, 4); host_write(16'h3000, 8'h99);
    host_rd_n = 1'b0;
    @(negedge clk);
    chk("R4 read while pending", 32'(host_ack_n), 32'd0);
    host_rd_n = 1'b1;
    do @(negedge clk); while (dmem_we_n);
    repeat (3) @(negedge clk);
    ext_wait_n = 1'b1;
    wait_idle();

    // R11 configuration change mid-access applies to next write
    cfg_dwait = 3'd0;
    push(1, 16'h4000, 16'h0001, 1); host_write(16'h4000, 8'h01);
    do @(negedge clk); while (dmem_we_n);
    cfg_dwait = 3'd7;
    wait_idle();
    push(1, 16'h4001, 16'h0002, 8); host_write(16'h4001, 8'h02); wait_idle();

    // R7 local write strobe holds off the take-over
    cfg_dwait = 3'd1; cpu_wr_n = 1'b0;
    push(1, 16'h5000, 16'h00c3, 2); host_write(16'h5000, 8'hc3);
    repeat (3) @(negedge clk);
    chk("R7 bus held while cpu writes", 32'(bus_local), 32'd1);
    cpu_wr_n = 1'b1;
    @(negedge clk);
    chk("R7 switch one cycle later", 32'(bus_local), 32'd0);
    wait_idle();

    // R4 R12 second write while pending, strobe rises in termination
    cfg_dwait = 3'd2;
    push(1, 16'h6000, 16'h00e1, 3); host_write(16'h6000, 8'he1);
    push(1, 16'h6001, 16'h00e2, 3);
    host_addr = 16'h6001; host_data = 8'he2; host_wr_n = 1'b0;
    @(negedge clk);
    chk("R4 second write stalled", 32'(host_ack_n), 32'd0);
    do @(negedge clk); while (host_ack_n == 1'b0);
    chk("R4 ack and pend released together", 32'(wr_pend_n), 32'd1);
    chk("R2 grant with release", 32'(lcl_gnt), 32'd1);
    host_wr_n = 1'b1;
    @(negedge clk);
    chk("R12 take-over cycle", 32'(bus_local), 32'd1);
    @(negedge clk);
    chk("R12 direct re-entry", 32'(bus_local), 32'd0);
    wait_idle();

    // R10 reset clears the byte flag
    cfg_sel = 2'b01; cfg_iwait = 2'd0;
    push(0, 16'h0030, 16'h0000, 0); host_write(16'h0030, 8'h55); wait_idle();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 pend after reset", 32'(wr_pend_n), 32'd1);
    push(0, 16'h0040, 16'h0000, 0); host_write(16'h0040, 8'h66); wait_idle();
    push(2, 16'h0041, 16'h7766, 1); host_write(16'h0041, 8'h77); wait_idle();

    chk("R6 scoreboard drained", 32'(exp_q.size()), 32'd0);
    summary();
    $finish;
  end
endmodule